// File: doc/BRIEF.md
# Five-Function Integer ALU with Flags

This block is a purely combinational 32-bit arithmetic-logic unit for the execute stage of a simple integer datapath. It takes two operands and a 3-bit control word and returns a result together with a zero flag and a signed-overflow flag. The control word is one invert-B bit followed by a 2-bit operation select. The supported operations are bitwise AND, bitwise OR, add, subtract and signed set-less-than.

Subtract and set-less-than share the adder. They invert the second operand and force the adder's carry-in to one. Set-less-than takes the sign of the difference and corrects it with the overflow condition, so the comparison stays right even when the subtraction wraps.

The adder is built from fixed-size carry-lookahead groups. A group-level lookahead chain links the groups. The width and the group size are parameters.

Top module: `fivefn_alu`

## Requirements
- R1: With control 3'b000 the result is the bitwise AND of the two operands.
- R2: With control 3'b001 the result is the bitwise OR of the two operands.
- R3: With control 3'b010 the result is the two's-complement sum of the operands modulo 2^32. The carry out of bit 31 is dropped.
- R4: With control 3'b110 the result is operand A minus operand B modulo 2^32. It is formed as A plus the inverse of B plus one.
- R5: With control 3'b111 the result bit 0 is 1 exactly when A is less than B as signed 32-bit values, and bits 31..1 are 0. This holds even when A minus B overflows.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every control value.
- R7: Under control 3'b010 the overflow flag is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R8: Under control 3'b110 the overflow flag is 1 exactly when the operands' sign bits differ and the difference's sign bit differs from A's.
- R9: For every control value other than 3'b010 and 3'b110, the overflow flag is 0. This includes 3'b111 with operands whose difference overflows.
- R10: The unused control values 3'b011, 3'b100 and 3'b101 give an all-zero result, and therefore a zero flag of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| ctrl | input | 3 | {invert-B, select[1:0]} operation code |
| result | output | 32 | Operation result |
| zero_o | output | 1 | High when result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
Signed overflow and set-less-than can both arise from the same difference. The comparison has to absorb the overflow while the flag itself stays hidden. The bench applies operand pairs whose difference wraps, such as 0x7FFFFFFF against 0x80000000 and the reverse, under both the subtract code and the set-less-than code. Under subtract it expects the overflow flag high. Under set-less-than it expects the correct signed ordering with the overflow flag low, and it also checks the zero flag that follows from that result.

// File: rtl/fivefn_alu_pkg.sv
package fivefn_alu_pkg;
  typedef enum logic [2:0] {
    OPC_AND = 3'b000,
    OPC_OR  = 3'b001,
    OPC_ADD = 3'b010,
    OPC_SUB = 3'b110,
    OPC_SLT = 3'b111
  } alu_op_e;

  localparam int unsigned CTRL_W = 3;
endpackage

// File: rtl/alu_cla_group.sv
module alu_cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grp_g,
  output logic          grp_p
);
  logic [GW-1:0] gen;
  logic [GW-1:0] prp;
  logic [GW:0]   cy;

  assign gen = a & b;
  assign prp = a | b;

  always_comb begin
    cy[0] = cin;
    for (int k = 0; k < GW; k++) begin
      cy[k+1] = gen[k] | (prp[k] & cy[k]);
    end
  end

  always_comb begin
    grp_g = 1'b0;
    grp_p = 1'b1;
    for (int k = 0; k < GW; k++) begin
      grp_g = gen[k] | (prp[k] & grp_g);
      grp_p = grp_p & prp[k];
    end
  end

  assign sum = a ^ b ^ cy[GW-1:0];
endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int unsigned W  = 32,
  parameter int unsigned GW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  localparam int unsigned NGRP = W / GW;

  logic [NGRP-1:0] g_grp;
  logic [NGRP-1:0] p_grp;
  logic [NGRP:0]   c_grp;

  always_comb begin
    c_grp[0] = cin;
    for (int j = 0; j < NGRP; j++) begin
      c_grp[j+1] = g_grp[j] | (p_grp[j] & c_grp[j]);
    end
  end

  for (genvar j = 0; j < NGRP; j++) begin : g_grp_inst
    alu_cla_group #(.GW(GW)) u_grp (
      .a     (a[j*GW +: GW]),
      .b     (b[j*GW +: GW]),
      .cin   (c_grp[j]),
      .sum   (sum[j*GW +: GW]),
      .grp_g (g_grp[j]),
      .grp_p (p_grp[j])
    );
  end
endmodule

// File: rtl/alu_bitwise_unit.sv
module alu_bitwise_unit #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o
);
  assign and_o = a & b;
  assign or_o  = a | b;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int unsigned W = 32
) (
  input  logic         a_sign,
  input  logic         b_eff_sign,
  input  logic         sum_sign,
  input  logic         arith_sel,
  input  logic [W-1:0] res,
  output logic         lt_o,
  output logic         ovf_o,
  output logic         zero_o
);
  logic raw_ovf;

  // Same-sign inputs to the adder with a sign change at its output.
  assign raw_ovf = (a_sign == b_eff_sign) && (sum_sign != a_sign);
  assign lt_o    = sum_sign ^ raw_ovf;
  assign ovf_o   = arith_sel & raw_ovf;
  assign zero_o  = ~(|res);
endmodule

// File: rtl/fivefn_alu.sv
module fivefn_alu
  import fivefn_alu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned GW = 4
) (
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [W-1:0]      result,
  output logic              zero_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = W - 1;

  alu_op_e     opc;
  logic        neg_b;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [W-1:0] and_r;
  logic [W-1:0] or_r;
  logic        lt_bit;
  logic        arith_sel;
  logic [W-1:0] res_nxt;

  assign opc       = alu_op_e'(ctrl);
  assign neg_b     = ctrl[CTRL_W-1];
  assign b_eff     = neg_b ? ~op_b : op_b;
  assign arith_sel = (opc == OPC_ADD) || (opc == OPC_SUB);

  alu_bitwise_unit #(.W(W)) u_bit (
    .a     (op_a),
    .b     (op_b),
    .and_o (and_r),
    .or_o  (or_r)
  );

  alu_cla_adder #(.W(W), .GW(GW)) u_add (
    .a   (op_a),
    .b   (b_eff),
    .cin (neg_b),
    .sum (sum)
  );

  always_comb begin
    unique case (opc)
      OPC_AND: res_nxt = and_r;
      OPC_OR:  res_nxt = or_r;
      OPC_ADD: res_nxt = sum;
      OPC_SUB: res_nxt = sum;
      OPC_SLT: res_nxt = {{(W-1){1'b0}}, lt_bit};
      default: res_nxt = '0;
    endcase
  end

  assign result = res_nxt;

  alu_flag_unit #(.W(W)) u_flg (
    .a_sign     (op_a[MSB]),
    .b_eff_sign (b_eff[MSB]),
    .sum_sign   (sum[MSB]),
    .arith_sel  (arith_sel),
    .res        (res_nxt),
    .lt_o       (lt_bit),
    .ovf_o      (ovf_o),
    .zero_o     (zero_o)
  );
endmodule

// File: rtl/fivefn_alu_chk.sv
module fivefn_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   ctrl,
  input logic [W-1:0] result,
  input logic         zero_o,
  input logic         ovf_o
);
  always_comb begin
    if (!$isunknown({op_a, op_b, ctrl, result, zero_o, ovf_o})) begin
      // R1
      and_res_chk: assert (ctrl != 3'b000 || result == (op_a & op_b));
      // R2
      or_res_chk: assert (ctrl != 3'b001 || result == (op_a | op_b));
      // R3
      add_res_chk: assert (ctrl != 3'b010 || result == op_a + op_b);
      // R4
      sub_res_chk: assert (ctrl != 3'b110 || result == op_a - op_b);
      // R5
      slt_res_chk: assert (ctrl != 3'b111 ||
        result == {{(W-1){1'b0}}, ($signed(op_a) < $signed(op_b))});
      // R6
      zero_flag_chk: assert (zero_o == (result == '0));
      // R9
      no_overflow_chk: assert (ctrl == 3'b010 || ctrl == 3'b110 || !ovf_o);
      // R10
      unused_code_chk: assert (!(ctrl == 3'b011 || ctrl[2:1] == 2'b10) || result == '0);
    end
  end
endmodule

bind fivefn_alu fivefn_alu_chk #(.W(W)) u_chk (
  .op_a   (op_a),
  .op_b   (op_b),
  .ctrl   (ctrl),
  .result (result),
  .zero_o (zero_o),
  .ovf_o  (ovf_o)
);

// File: tb/sim_fivefn_alu.sv
module sim_fivefn_alu;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [2:0]  ctrl;
  logic [31:0] result;
  logic        zero_o;
  logic        ovf_o;
  int          total;
  int          bad;
  bit          done;

  fivefn_alu u0 (
    .op_a   (op_a),
    .op_b   (op_b),
    .ctrl   (ctrl),
    .result (result),
    .zero_o (zero_o),
    .ovf_o  (ovf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {ctrl, a, b, expected result, expected zero, expected ovf, req}
  localparam int NV = 21;
  localparam logic [108:0] VEC [NV] = '{
    {3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0, 8'd1},  // R1
    {3'b000, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h00000000, 1'b1, 1'b0, 8'd1},  // R1 R6
    {3'b001, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF, 1'b0, 1'b0, 8'd2},  // R2
    {3'b001, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 8'd2},  // R2 R6
    {3'b010, 32'h00000005, 32'h00000003, 32'h00000008, 1'b0, 1'b0, 8'd3},  // R3
    {3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b0, 1'b0, 8'd3},  // R3 carry dropped
    {3'b010, 32'h0000FFFF, 32'h00000001, 32'h00010000, 1'b0, 1'b0, 8'd3},  // R3 group chain
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 8'd7},  // R7 pos+pos
    {3'b010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1, 8'd7},  // R7 neg+neg
    {3'b110, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0, 8'd4},  // R4 R6
    {3'b110, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b0, 1'b0, 8'd4},  // R4
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 8'd8},  // R8
    {3'b110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1, 8'd8},  // R8
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 8'd5},  // R5
    {3'b111, 32'h00000001, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 8'd5},  // R5
    {3'b111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 8'd5},  // R5 R9 wrap
    {3'b111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 8'd5},  // R5 R9 wrap
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 8'd10}, // R10
    {3'b100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 8'd10}, // R10
    {3'b101, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 8'd10}, // R10
    {3'b000, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0, 8'd9}   // R9
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    ctrl = c;
    op_a = a;
    op_b = b;
    #1;
  endtask

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    ctrl  = 3'b000;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state outputs with idle inputs: AND of zeros (R1, R6)
    @(negedge clk); #1;
    check32("R1 idle result", result, 32'h0);
    check32("R6 idle zero", {31'b0, zero_o}, 32'h1);
    check32("R9 idle ovf", {31'b0, ovf_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [108:0] v;
      string tg;
      v = VEC[i];
      drive(v[108:106], v[105:74], v[73:42]);
      tg = $sformatf("R%0d vec%0d", v[7:0], i);
      check32({tg, " result"}, result, v[41:10]);
      check32({"R6 ", tg, " zero"}, {31'b0, zero_o}, {31'b0, v[9]});
      check32({tg, " ovf (R7/R8/R9)"}, {31'b0, ovf_o}, {31'b0, v[8]});
    end

    // R3: carry ripple across every bit position
    for (int k = 0; k < 32; k++) begin
      logic [31:0] lowmask;
      lowmask = (32'h1 << k) - 32'h1;
      drive(3'b010, lowmask, 32'h1);
      check32($sformatf("R3 carry walk k=%0d", k), result, 32'h1 << k);
    end

    // R4 R5: subtract and compare on same pair, magnitude sweep
    for (int k = 0; k < 31; k++) begin
      logic [31:0] x;
      x = 32'h1 << k;
      drive(3'b110, x, x + 32'h1);
      check32($sformatf("R4 sub k=%0d", k), result, 32'hFFFFFFFF);
      drive(3'b111, x, x + 32'h1);
      check32($sformatf("R5 slt k=%0d", k), result, 32'h1);
    end

    // R9: overflowing operands under non-arith codes leave ovf low
    drive(3'b001, 32'h7FFFFFFF, 32'h00000001);
    check32("R9 or ovf", {31'b0, ovf_o}, 32'h0);
    drive(3'b111, 32'h80000000, 32'h00000001);
    check32("R9 slt ovf", {31'b0, ovf_o}, 32'h0);
    check32("R5 slt most-negative", result, 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1..R10 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule